// File: doc/BRIEF.md
# Two-Compare Periodic Strobe and Start Trigger Timer

This block is a self-running cycle counter with two compare points. It produces a periodic output strobe and a start trigger for a downstream transfer engine, and it needs no processor action once it is enabled. When the count reaches the lower compare value, the strobe pin is driven low. When the count reaches the upper compare value, three things happen in the same event: the pin is driven high again, a one-cycle start pulse is issued, and the counter returns to zero. The pin pulse and the transfer trigger therefore stay locked in phase, and the upper compare value alone sets the repeat period.

Software-facing compare inputs are staged. They take effect only at a wrap, while the timer is disabled, or while the configuration is invalid, so a period that is already running is never cut short or stretched. A configuration where the lower compare is not strictly below the upper one is reported on an error output. In that state the pin is parked at its idle high level and no events are issued.

Top module: `trig_timer`

## Requirements
- R1: While `enable_i` is low (and out of reset), `strobe_o` is high, `start_o`, `hit_lo_o`, `hit_hi_o` and `cfg_err_o` are low, and the counter is held at zero.
- R2: When the running count equals the active lower compare value, `hit_lo_o` pulses in that cycle and `strobe_o` is low from the next cycle on.
- R3: When the running count equals the active upper compare value, `hit_hi_o` and `start_o` pulse together in that cycle and `strobe_o` is high from the next cycle on.
- R4: An upper-compare event returns the count to zero, so with active values L < H consecutive `start_o` pulses are exactly H+1 clock cycles apart. The first count after enable is 0.
- R5: New compare inputs are taken into the active registers only in a cycle with an upper-compare event, while disabled, or while in error. A change in the middle of a period leaves that period unchanged.
- R6: If the active lower compare is greater than or equal to the active upper compare while enabled, `cfg_err_o` is high, `strobe_o` is held high and no events or start pulses occur. Valid inputs are taken up again on the next cycle.
- R7: Every event output (`hit_lo_o`, `hit_hi_o`, `start_o`) is a single-cycle pulse and is never high in two consecutive cycles.
- R8: With a lower compare of 0, `strobe_o` is high for exactly one cycle per period and low for the remaining H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Run enable; low holds the counter at zero |
| cmp_lo_i | input | CNT_W | Staged compare value at which the strobe falls |
| cmp_hi_i | input | CNT_W | Staged compare value at which the strobe rises, start fires and the count wraps |
| strobe_o | output | 1 | Periodic strobe pin level, idle high |
| start_o | output | 1 | One-cycle start trigger for the transfer engine |
| hit_lo_o | output | 1 | One-cycle lower compare event |
| hit_hi_o | output | 1 | One-cycle upper compare event |
| cfg_err_o | output | 1 | High while enabled with lower compare not below upper compare |

## Verification
Two pairs of functions can fall in the same cycle. The first is the upper-compare event together with the reload of staged compare values. The bench provokes it by changing both compare inputs in the middle of a period and judges that the old period still finishes before the new timing appears. The second is the strobe rising together with the start pulse. A queue-based reference model judges that both occur on the wrap cycle and that the start spacing matches H+1. The lower-compare value of zero places the falling event in the cycle right after the wrap, which checks that the one-cycle high strobe is not lost.

// File: rtl/trig_timer_pkg.sv
// Package: shared types and constants for the two-compare trigger timer.
// Assumes: consumers import it before declaring ports that use its types.
package trig_timer_pkg;

    // Idle (inactive) level of the strobe pin.
    localparam logic STROBE_IDLE = 1'b1;

    // Decoded compare hits for one cycle.
    typedef struct packed {
        logic lo;
        logic hi;
    } hit_t;

endpackage

// File: rtl/trig_timer_shadow.sv
// Module: staging register pair for the two compare values.
// Holds the active compare values; copies the staged inputs only when
// load_i is high. Assumes load_i is asserted at wrap, when idle or on error.
module trig_timer_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic [CNT_W-1:0] lo_o,
    output logic [CNT_W-1:0] hi_o
);

    // Capture staged compare values on a permitted load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
        end else if (load_i) begin
            lo_o <= lo_i;
            hi_o <= hi_i;
        end
    end

endmodule

// File: rtl/trig_timer_count.sv
// Module: period counter.
// Counts up by one per cycle while run_i is high, clears on wrap_i and is
// held at zero while run_i is low. Assumes the wrap point never exceeds
// the counter range, so no overflow handling is needed.
module trig_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             wrap_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance, clear on wrap, or hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (!run_i || wrap_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + ONE;
        end
    end

endmodule

// File: rtl/trig_timer_match.sv
// Module: compare decoder.
// Flags equality of the count with each active compare value, qualified by
// run_i. Assumes lo < hi whenever run_i is high, so both hits never coincide.
module trig_timer_match #(
    parameter int CNT_W = 16
) (
    input  logic                  run_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic [CNT_W-1:0]      lo_i,
    input  logic [CNT_W-1:0]      hi_i,
    output trig_timer_pkg::hit_t  hit_o
);

    localparam int N_CMP = 2;

    logic [N_CMP-1:0] eq;
    logic [CNT_W-1:0] ref_val [N_CMP];

    assign ref_val[0] = lo_i;
    assign ref_val[1] = hi_i;

    // One equality comparator per compare channel.
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign eq[g] = run_i && (cnt_i == ref_val[g]);
    end

    // Pack the per-channel results into the hit record.
    always_comb begin
        hit_o.lo = eq[0];
        hit_o.hi = eq[1];
    end

endmodule

// File: rtl/trig_timer_pin.sv
// Module: strobe pin register.
// Falls on a lower hit, rises on an upper hit, rests high while stopped.
// Assumes the hit record is qualified by run_i already.
module trig_timer_pin (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  trig_timer_pkg::hit_t hit_i,
    output logic                 pin_o
);

    import trig_timer_pkg::*;

    // Update the strobe level from the compare hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= STROBE_IDLE;
        end else if (!run_i || hit_i.hi) begin
            pin_o <= STROBE_IDLE;
        end else if (hit_i.lo) begin
            pin_o <= ~STROBE_IDLE;
        end
    end

endmodule

// File: rtl/trig_timer.sv
// Module: two-compare periodic strobe and start trigger timer (top).
// Runs a counter from 0 to the upper compare value. The lower compare drops
// the strobe; the upper compare raises it, fires start and wraps the count.
// Assumes compare inputs are static long enough to be caught on a load cycle.
module trig_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] cmp_lo_i,
    input  logic [CNT_W-1:0] cmp_hi_i,
    output logic             strobe_o,
    output logic             start_o,
    output logic             hit_lo_o,
    output logic             hit_hi_o,
    output logic             cfg_err_o
);

    import trig_timer_pkg::*;

    logic [CNT_W-1:0] act_lo;
    logic [CNT_W-1:0] act_hi;
    logic [CNT_W-1:0] cnt;
    logic             bad_cfg;
    logic             run;
    logic             load;
    hit_t             hit;

    // Ordering check on the active compare pair.
    assign bad_cfg = (act_lo >= act_hi);
    assign run     = enable_i && !bad_cfg;
    assign load    = !run || hit.hi;

    trig_timer_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .lo_i   (cmp_lo_i),
        .hi_i   (cmp_hi_i),
        .lo_o   (act_lo),
        .hi_o   (act_hi)
    );

    trig_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .wrap_i (hit.hi),
        .cnt_o  (cnt)
    );

    trig_timer_match #(.CNT_W(CNT_W)) u_match (
        .run_i (run),
        .cnt_i (cnt),
        .lo_i  (act_lo),
        .hi_i  (act_hi),
        .hit_o (hit)
    );

    trig_timer_pin u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .hit_i (hit),
        .pin_o (strobe_o)
    );

    // Drive event and status outputs.
    assign hit_lo_o  = hit.lo;
    assign hit_hi_o  = hit.hi;
    assign start_o   = hit.hi;
    assign cfg_err_o = enable_i && bad_cfg;

endmodule

// File: rtl/trig_timer_checker.sv
// Module: property checker for trig_timer, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module trig_timer_checker (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic strobe_o,
    input logic start_o,
    input logic hit_lo_o,
    input logic hit_hi_o,
    input logic cfg_err_o
);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> strobe_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !(start_o || hit_lo_o || hit_hi_o || cfg_err_o));

    p_fall_after_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo_o |=> !strobe_o);

    p_rise_after_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi_o |=> strobe_o);

    p_start_with_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> hit_hi_o);

    p_err_parks_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (strobe_o && !start_o && !hit_lo_o));

    p_hi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi_o |=> !hit_hi_o);

    p_lo_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo_o |=> !hit_lo_o);

endmodule

bind trig_timer trig_timer_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .strobe_o  (strobe_o),
    .start_o   (start_o),
    .hit_lo_o  (hit_lo_o),
    .hit_hi_o  (hit_hi_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/trig_timer_tb.sv
// Bench: scoreboard for trig_timer. A reference model built from the
// requirements pushes expected outputs into a queue; a monitor pops and
// compares them against the design every cycle.
module trig_timer_tb;

    localparam int CNT_W = 16;

    typedef struct {
        logic pin;
        logic start;
        logic lo;
        logic hi;
        logic err;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_i = 1'b0;
    logic [CNT_W-1:0] cmp_lo_i = '0;
    logic [CNT_W-1:0] cmp_hi_i = '0;
    logic             strobe_o, start_o, hit_lo_o, hit_hi_o, cfg_err_o;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    int    exp_period = 0;
    bit    done = 1'b0;
    exp_t  q[$];

    // Reference model state.
    logic [CNT_W-1:0] m_cnt = '0, m_lo = '0, m_hi = '0;
    logic             m_pin = 1'b1;

    // Start-spacing tracker.
    int gap = 0;
    bit gap_ok = 1'b0;

    trig_timer #(.CNT_W(CNT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .enable_i (enable_i),
        .cmp_lo_i (cmp_lo_i), .cmp_hi_i (cmp_hi_i),
        .strobe_o (strobe_o), .start_o (start_o),
        .hit_lo_o (hit_lo_o), .hit_hi_o (hit_hi_o), .cfg_err_o (cfg_err_o)
    );

    always #4 clk = ~clk;

    // Model: advance state at each edge per the requirements.
    always @(posedge clk) begin
        logic run, hh, hl;
        if (!rst_n) begin
            m_cnt = '0; m_lo = '0; m_hi = '0; m_pin = 1'b1;
        end else begin
            run = enable_i && (m_lo < m_hi);
            hh  = run && (m_cnt == m_hi);
            hl  = run && (m_cnt == m_lo);
            if (!run || hh) begin
                m_cnt = '0; m_pin = 1'b1;
            end else begin
                m_cnt = m_cnt + 1'b1;
                if (hl) m_pin = 1'b0;
            end
            if (!run || hh) begin
                m_lo = cmp_lo_i; m_hi = cmp_hi_i;
            end
        end
    end

    // Driver side of the scoreboard: push the expectation for this cycle.
    always @(negedge clk) begin
        exp_t e;
        logic run;
        run     = rst_n && enable_i && (m_lo < m_hi);
        e.pin   = m_pin;
        e.hi    = run && (m_cnt == m_hi);
        e.lo    = run && (m_cnt == m_lo);
        e.start = e.hi;
        e.err   = rst_n && enable_i && (m_lo >= m_hi);
        q.push_back(e);
    end

    task automatic cmp1(string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Monitor: pop expectation and compare; also check start spacing.
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (q.size() != 0) begin
            e = q.pop_front();
            cmp1("strobe_o(R2)", strobe_o, e.pin);
            cmp1("hit_lo_o(R2)", hit_lo_o, e.lo);
            cmp1("hit_hi_o(R3)", hit_hi_o, e.hi);
            cmp1("start_o(R3)", start_o, e.start);
            cmp1("cfg_err_o(R6)", cfg_err_o, e.err);
        end
        gap++;
        if (start_o === 1'b1) begin
            if (gap_ok) begin
                n_vec++;
                if (gap == 1) begin
                    n_bad++;
                    $display("FAIL R7 start repeated actual_gap=%0d expected>1", gap);
                end
                if (exp_period != 0) begin
                    n_vec++;
                    if (gap != exp_period) begin
                        n_bad++;
                        $display("FAIL R4 start spacing actual=%0d expected=%0d", gap, exp_period);
                    end
                end
            end
            gap = 0;
            gap_ok = 1'b1;
        end
    end

    task automatic setv(int lo, int hi);
        cmp_lo_i = CNT_W'(lo);
        cmp_hi_i = CNT_W'(hi);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Stimulus sequence.
    initial begin
        setv(3, 9);
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);                 // R1 idle state
        tag = "R2"; enable_i = 1'b1;
        wait_cyc(25);
        tag = "R4"; exp_period = 10;
        wait_cyc(35);
        tag = "R5"; exp_period = 0;
        wait_cyc(4);                 // now mid-period
        setv(2, 5);
        wait_cyc(30);
        setv(0, 4);
        wait_cyc(12);
        tag = "R8"; exp_period = 5;
        wait_cyc(25);
        tag = "R6"; exp_period = 0;
        setv(7, 7);
        wait_cyc(15);
        setv(8, 3);
        wait_cyc(10);
        setv(1, 6);
        wait_cyc(20);
        tag = "R1"; enable_i = 1'b0;
        wait_cyc(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule